// File: doc/BRIEF.md
# T1 Per-Slot Idle and Zero-Suppression Conditioner

This block sits in the transmit direction of a T1 framer, between the system-side octet stream and the framing and line-coding stages. Each 193-bit frame arrives as one framing octet followed by the 24 DS0 channel octets, one octet per valid cycle. Each octet comes with a slot index and a marker for the framing octet. The block rewrites the channel octets in two steps. First, slots chosen by a 24-bit idle mask have their content replaced by a programmable 8-bit idle pattern. Second, when AMI line coding with zero code suppression is selected, an all-zero octet has its seventh transmitted bit forced to one. Slots flagged in a clear-channel mask are exempt from this second step.

Configuration is taken from four static-looking inputs, but it is sampled only when the framing octet is accepted. A whole frame is therefore rewritten with one consistent setting. The framing octet itself passes through untouched. The result appears one clock later, with valid, framing marker and slot index delayed to match.

Top module: `t1_slot_conditioner`

## Requirements
- R1: After reset, out_valid is 0, and until the first framing octet the working configuration is all cleared: no idle slots, no clear slots, suppression off.
- R2: Each accepted octet appears on the outputs exactly one clock later, with out_valid, out_fbit and out_slot equal to the in_valid, in_fbit and in_slot of the previous cycle. A cycle with in_valid low produces out_valid low.
- R3: An octet with in_fbit high (the framing octet, framing bit in in_data[0]) is output unchanged whatever the configuration.
- R4: A channel octet whose slot index k (0 to 23, index k is slot k+1) has bit k of the working idle mask set is replaced by the working idle pattern.
- R5: With suppression on, a channel octet equal to 8'h00 after idle substitution, in a slot whose clear-mask bit is 0, is output as 8'h02. This is bit 7 of the MSB-first transmission order set to one.
- R6: A slot whose working clear-mask bit is 1 is never suppressed, so zero octets pass as 8'h00.
- R7: With suppression off, zero octets pass unchanged in every slot.
- R8: Idle substitution is applied before suppression, so an all-zero idle pattern in a non-clear slot with suppression on goes out as 8'h02.
- R9: The idle mask, idle pattern, clear mask and suppression enable are captured into the working configuration only on an accepted framing octet. Changes made within a frame have no effect on that frame's channel octets.
- R10: Non-zero channel octets in slots not marked idle pass unchanged, and slot indices above 23 are treated as neither idle nor clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input octet valid |
| in_fbit | input | 1 | Input octet is the framing octet |
| in_slot | input | 5 | Channel slot index 0..23 |
| in_data | input | 8 | Input octet, MSB transmitted first |
| cfg_idle_mask | input | 24 | Per-slot idle select, bit k = slot index k |
| cfg_idle_pat | input | 8 | Idle replacement pattern |
| cfg_clear_mask | input | 24 | Per-slot suppression exemption |
| cfg_zcs_en | input | 1 | Enable zero code suppression |
| out_valid | output | 1 | Output octet valid |
| out_fbit | output | 1 | Output octet is the framing octet |
| out_slot | output | 5 | Delayed slot index |
| out_data | output | 8 | Rewritten octet |

## Verification
The bench changes configuration in the middle of frames at random points. A design that applied settings at once, rather than at the framing octet, would then rewrite part of a frame with the wrong mask. It also drives an all-zero idle pattern. A design that suppressed before substituting would send 8'h00 there instead of 8'h02. Directed cases cover the framing octet carrying zero under full idle and suppression, and zero octets in clear slots. They also cover the cleared configuration before the first framing octet and idle cycles between octets. A design that mapped mask bits off by one slot, or that touched the framing octet, would show a wrong octet in those cases.

// File: rtl/t1_cond_pkg.sv
package t1_cond_pkg;
    localparam int NUM_SLOTS = 24;
    localparam int OCT_W     = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
    localparam logic [OCT_W-1:0] STUFF_OCT = 8'h02;

    typedef logic [NUM_SLOTS-1:0] slot_mask_t;
    typedef logic [OCT_W-1:0]     octet_t;
    typedef logic [SLOT_W-1:0]    slot_idx_t;

    typedef struct packed {
        slot_mask_t idle_mask;
        octet_t     idle_pat;
        slot_mask_t clear_mask;
        logic       zcs_en;
    } frame_cfg_t;

    typedef struct packed {
        logic      valid;
        logic      fbit;
        slot_idx_t slot;
        octet_t    data;
    } lane_t;

    function automatic logic mask_pick(input slot_mask_t m, input slot_idx_t s);
        if (int'(s) < NUM_SLOTS) return m[s];
        return 1'b0;
    endfunction
endpackage

// File: rtl/t1_cfg_shadow.sv
module t1_cfg_shadow
    import t1_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  frame_cfg_t cfg_in,
    output frame_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else if (load) cfg_q <= cfg_in;
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/t1_slot_rewrite.sv
module t1_slot_rewrite
    import t1_cond_pkg::*;
(
    input  frame_cfg_t cfg,
    input  lane_t      lane_in,
    output octet_t     data_out
);
    logic   idle_hit;
    logic   clear_hit;
    octet_t after_idle;

    always_comb begin
        idle_hit   = mask_pick(cfg.idle_mask, lane_in.slot);
        clear_hit  = mask_pick(cfg.clear_mask, lane_in.slot);
        after_idle = idle_hit ? cfg.idle_pat : lane_in.data;
        if (lane_in.fbit)
            data_out = lane_in.data;
        else if (cfg.zcs_en && !clear_hit && after_idle == '0)
            data_out = STUFF_OCT;
        else
            data_out = after_idle;
    end

    always_comb begin
        if (lane_in.valid && !lane_in.fbit && cfg.zcs_en && !clear_hit)
            AST_NO_ZERO_OUT: assert (data_out != '0); // R5
        if (lane_in.valid && !lane_in.fbit && idle_hit && cfg.idle_pat != '0)
            AST_IDLE_SUBST: assert (data_out == cfg.idle_pat); // R4
    end
endmodule

// File: rtl/t1_slot_conditioner.sv
module t1_slot_conditioner
    import t1_cond_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_fbit,
    input  logic [SLOT_W-1:0]    in_slot,
    input  logic [OCT_W-1:0]     in_data,
    input  logic [NUM_SLOTS-1:0] cfg_idle_mask,
    input  logic [OCT_W-1:0]     cfg_idle_pat,
    input  logic [NUM_SLOTS-1:0] cfg_clear_mask,
    input  logic                 cfg_zcs_en,
    output logic                 out_valid,
    output logic                 out_fbit,
    output logic [SLOT_W-1:0]    out_slot,
    output logic [OCT_W-1:0]     out_data
);
    frame_cfg_t cfg_new, cfg_work;
    lane_t      lane_in, lane_q;
    octet_t     rewritten;
    logic       frame_start;

    always_comb begin
        cfg_new.idle_mask  = cfg_idle_mask;
        cfg_new.idle_pat   = cfg_idle_pat;
        cfg_new.clear_mask = cfg_clear_mask;
        cfg_new.zcs_en     = cfg_zcs_en;
        lane_in.valid      = in_valid;
        lane_in.fbit       = in_fbit;
        lane_in.slot       = in_slot;
        lane_in.data       = in_data;
        frame_start        = in_valid && in_fbit;
    end

    t1_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_start),
        .cfg_in (cfg_new),
        .cfg_q  (cfg_work)
    );

    t1_slot_rewrite u_rewrite (
        .cfg      (cfg_work),
        .lane_in  (lane_in),
        .data_out (rewritten)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else begin
            lane_q.valid <= in_valid;
            lane_q.fbit  <= in_fbit;
            lane_q.slot  <= in_slot;
            lane_q.data  <= rewritten;
        end
    end

    assign out_valid = lane_q.valid;
    assign out_fbit  = lane_q.fbit;
    assign out_slot  = lane_q.slot;
    assign out_data  = lane_q.data;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_SLOT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_slot == $past(in_slot) && out_fbit == $past(in_fbit))); // R2
    AST_FBIT_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fbit) |=> out_data == $past(in_data)); // R3
endmodule

// File: tb/t1_slot_conditioner_bench.sv
module t1_slot_conditioner_bench;
    import t1_cond_pkg::*;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_fbit = 0;
    logic [SLOT_W-1:0] in_slot = '0;
    logic [7:0] in_data = '0;
    logic [23:0] cfg_idle_mask = '0, cfg_clear_mask = '0;
    logic [7:0] cfg_idle_pat = '0;
    logic cfg_zcs_en = 0;
    logic out_valid, out_fbit;
    logic [SLOT_W-1:0] out_slot;
    logic [7:0] out_data;

    int n_chk = 0, n_fail = 0;
    logic [23:0] m_idle = '0, m_clear = '0;
    logic [7:0]  m_pat = '0;
    logic        m_zcs = 0;

    always #4 clk = ~clk;

    t1_slot_conditioner u_t1_slot_conditioner (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fbit(in_fbit),
        .in_slot(in_slot), .in_data(in_data), .cfg_idle_mask(cfg_idle_mask),
        .cfg_idle_pat(cfg_idle_pat), .cfg_clear_mask(cfg_clear_mask),
        .cfg_zcs_en(cfg_zcs_en), .out_valid(out_valid), .out_fbit(out_fbit),
        .out_slot(out_slot), .out_data(out_data));

    function automatic logic [7:0] model(input logic f, input int s, input logic [7:0] d);
        logic [7:0] v;
        logic idl, clr;
        if (f) return d;
        idl = (s < 24) ? m_idle[s] : 1'b0;
        clr = (s < 24) ? m_clear[s] : 1'b0;
        v = idl ? m_pat : d;
        if (m_zcs && !clr && v == 8'h00) v = 8'h02;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic f, input int s, input logic [7:0] d,
                        input string req);
        logic [7:0] e;
        @(negedge clk);
        in_valid = v; in_fbit = f; in_slot = s[SLOT_W-1:0]; in_data = d;
        e = model(f, s, d);
        @(posedge clk); #1;
        check({req, " valid"}, {31'd0, out_valid}, {31'd0, v});
        if (v) begin
            check({req, " data"}, {24'd0, out_data}, {24'd0, e});
            check("R2 slot", {27'd0, out_slot}, {27'd0, s[SLOT_W-1:0]});
            check("R2 fbit", {31'd0, out_fbit}, {31'd0, f});
        end
        if (v && f) begin
            m_idle = cfg_idle_mask; m_clear = cfg_clear_mask;
            m_pat = cfg_idle_pat; m_zcs = cfg_zcs_en;
        end
    endtask

    task automatic set_cfg(input logic [23:0] im, input logic [7:0] p,
                           input logic [23:0] cm, input logic z);
        cfg_idle_mask = im; cfg_idle_pat = p; cfg_clear_mask = cm; cfg_zcs_en = z;
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        // R1: before any framing octet, config applied is cleared even if inputs set
        set_cfg(24'hFFFFFF, 8'h55, 24'h0, 1'b1);
        send(1, 0, 0, 8'h00, "R1 no cfg before F");
        send(1, 0, 5, 8'h3C, "R1 no idle before F");
        // R3: framing octet zero under full idle + zcs
        send(1, 1, 0, 8'h00, "R3 fbit untouched");
        send(1, 0, 0, 8'h11, "R4 idle slot1");
        send(1, 0, 23, 8'h11, "R4 idle slot24");
        send(0, 0, 1, 8'h00, "R2 gap");
        // R6 clear exemption, R7 zcs off, R8 zero idle pattern
        set_cfg(24'h000004, 8'h00, 24'h000002, 1'b1);
        send(1, 1, 0, 8'h01, "R3 fbit");
        send(1, 0, 1, 8'h00, "R6 clear slot");
        send(1, 0, 2, 8'hA5, "R8 zero idle stuffed");
        send(1, 0, 3, 8'h00, "R5 stuff");
        send(1, 0, 4, 8'h81, "R10 passthrough");
        send(1, 0, 30, 8'h00, "R10 out-of-range slot");
        // R9: mid-frame change ignored
        set_cfg(24'h000008, 8'h77, 24'h000008, 1'b0);
        send(1, 0, 3, 8'h00, "R9 mid-frame ignored");
        send(1, 1, 0, 8'h00, "R3 fbit");
        send(1, 0, 3, 8'h00, "R4 new idle applied");
        send(1, 0, 5, 8'h00, "R7 zcs off");
        // random frames with mid-frame config changes
        for (int fr = 0; fr < 60; fr++) begin
            send(1, 1, 0, 8'($urandom), "R3 random fbit");
            for (int s = 0; s < 24; s++) begin
                if ($urandom_range(0, 9) == 0)
                    set_cfg(24'($urandom), ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom),
                            24'($urandom), 1'($urandom));
                if ($urandom_range(0, 7) == 0) send(0, 0, s, 8'h00, "R2 random gap");
                send(1, 0, s, ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom),
                     "R9 random slot");
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule